// File: doc/BRIEF.md
# CW Break-in Hang Timer

This block decides when a Morse keyer puts the transmitter on the air and when it hands back to receive. A debounced key line comes in. Two registered outputs go out: a transmit request, which rises as soon as the key closes, and a keying gate, which follows the key one cycle later. When the key opens, a hang counter paced by an external prescaler tick keeps the transmit request up for a chosen number of ticks. If the key closes again inside that window, the counter restarts and transmit never drops.

The hang length comes from a 3-bit setting or from an automatic mode. Setting zero is full break-in, which uses a two-tick hang. Settings one to seven are semi break-in with longer fixed hangs, and setting seven is the shortest of those. In automatic mode, every key closure starts a fixed-length pulse. A shift-weighted exponential filter averages the pulse train once per tick. A constant divided by that average gives a hang of roughly five dot lengths, so transmit is held across letter gaps and released at word gaps. Turning automatic mode off clears the average at once.

Top module: `cw_hang_timer`

## Requirements
- R1: A high key_in sampled at a clock edge makes tx_req high after that edge. key_gate equals key_in as sampled at the previous clock edge.
- R2: After the key opens, tx_req stays high and falls on the H-th clock edge that has tick high and key_in low. Here H is the hang length latched at the last edge with the key closed. Edges without tick do not advance the count.
- R3: A key closure during the hang keeps tx_req high. After the next release, the full hang H runs again.
- R4: With auto_en low and mode_sel = 0 (full break-in), H = 2 ticks.
- R5: With auto_en low and mode_sel = n for n = 1..7, H = 150 + 100*(7-n) ticks. Every one of these is longer than the full break-in hang, and n = 7 is the shortest semi hang.
- R6: auto_en high selects the automatic hang whatever mode_sel holds. Each rising edge of key_in loads an 8-tick pulse, which retriggers if already running. The pulse counts down on ticks.
- R7: While auto_en is high, on each edge with tick high, a 20-bit average A is updated using the pulse state from before that edge. If the pulse is active, A becomes A + ((2^20-1-A)>>11). If not, A becomes A - (A>>11).
- R8: The automatic hang uses q = A>>8 (12 bits). H = 45875/q, limited to the range 100..1200 ticks, and H = 1200 when q = 0. Faster keying therefore gives a shorter hang.
- R9: An edge with auto_en low clears A to zero. The next automatic hang latched from a cleared average is 1200 ticks.
- R10: Synchronous active-high reset drives tx_req and key_gate low and clears A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler timing strobe, one clock wide |
| key_in | input | 1 | Debounced key, high when closed |
| auto_en | input | 1 | Selects the automatic hang |
| mode_sel | input | 3 | Break-in setting: 0 full, 1..7 semi |
| tx_req | output | 1 | Transmit request |
| key_gate | output | 1 | Registered key for the carrier gate |

## Verification
The hardest state to reach from the ports is a known, settled value of the keying-rate average. It is only visible as the length of the next automatic hang, and it takes thousands of ticks to settle. The stimulus drives long periodic keying trains at three speeds, then closes the key once and counts ticks until transmit drops. A tick-accurate bench model of the pulse and filter predicts the result. Random keying with random tick gaps then checks the same prediction. A single cycle with the automatic mode turned off exercises the fast clear.

// File: rtl/cwh_pkg.sv
package cwh_pkg;
  typedef enum logic [1:0] {
    BRK_FULL = 2'd0,
    BRK_SEMI = 2'd1,
    BRK_AUTO = 2'd2
  } brk_kind_e;
endpackage

// File: rtl/cwh_rate_avg.sv
// Key-closure pulse generator and shift-weighted exponential average.
module cwh_rate_avg #(
  parameter int PULSE_TICKS = 8,
  parameter int AVG_W       = 20,
  parameter int AVG_SHIFT   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             key_in,
  input  logic             auto_en,
  output logic [AVG_W-1:0] avg_q
);
  localparam int PULSE_W = $clog2(PULSE_TICKS + 1);
  localparam logic [AVG_W-1:0] FULL_SCALE = '1;

  logic               key_prev;
  logic [PULSE_W-1:0] pulse_cnt;
  logic               press;
  logic               pulse_on;

  assign press    = key_in && !key_prev;
  assign pulse_on = (pulse_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_prev  <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      key_prev <= key_in;
      if (press)
        pulse_cnt <= PULSE_W'(PULSE_TICKS);
      else if (tick && pulse_on)
        pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  // The filter step uses the pulse state from before this edge.
  always_ff @(posedge clk) begin
    if (rst || !auto_en)
      avg_q <= '0;
    else if (tick) begin
      if (pulse_on)
        avg_q <= avg_q + ((FULL_SCALE - avg_q) >> AVG_SHIFT);
      else
        avg_q <= avg_q - (avg_q >> AVG_SHIFT);
    end
  end
endmodule

// File: rtl/cwh_hold_select.sv
// Picks the hang length: full, one of the semi levels, or rate-derived.
module cwh_hold_select
  import cwh_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int HOLD_W     = 11,
  parameter int QUO_W      = 12,
  parameter int FULL_HOLD  = 2,
  parameter int SEMI_MIN   = 150,
  parameter int SEMI_STEP  = 100,
  parameter int AUTO_SCALE = 45875,
  parameter int AUTO_MIN   = 100,
  parameter int AUTO_MAX   = 1200
) (
  input  logic [SEL_W-1:0]  mode_sel,
  input  logic              auto_en,
  input  logic [QUO_W-1:0]  avg_hi,
  output logic [HOLD_W-1:0] hold_ticks
);
  localparam int LEVELS = 2 ** SEL_W;

  logic [HOLD_W-1:0] level_tab [LEVELS];
  brk_kind_e         kind;
  logic [31:0]       quo;
  logic [HOLD_W-1:0] auto_hold;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    if (g == 0) begin : g_full
      assign level_tab[g] = HOLD_W'(FULL_HOLD);
    end else begin : g_semi
      assign level_tab[g] = HOLD_W'(SEMI_MIN + (LEVELS - 1 - g) * SEMI_STEP);
    end
  end

  always_comb begin
    if (auto_en)               kind = BRK_AUTO;
    else if (mode_sel == '0)   kind = BRK_FULL;
    else                       kind = BRK_SEMI;
  end

  always_comb begin
    if (avg_hi == '0)
      quo = 32'(AUTO_MAX);
    else
      quo = 32'(AUTO_SCALE) / 32'(avg_hi);
    if (quo < 32'(AUTO_MIN))
      auto_hold = HOLD_W'(AUTO_MIN);
    else if (quo > 32'(AUTO_MAX))
      auto_hold = HOLD_W'(AUTO_MAX);
    else
      auto_hold = quo[HOLD_W-1:0];
  end

  always_comb begin
    unique case (kind)
      BRK_AUTO: hold_ticks = auto_hold;
      default:  hold_ticks = level_tab[mode_sel];
    endcase
  end
endmodule

// File: rtl/cwh_hold_timer.sv
// Transmit request with tick-paced hang counter, reloaded while keyed.
module cwh_hold_timer #(
  parameter int HOLD_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              key_in,
  input  logic [HOLD_W-1:0] hold_ticks,
  output logic              tx_req,
  output logic              key_gate
);
  logic [HOLD_W-1:0] hang_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req   <= 1'b0;
      key_gate <= 1'b0;
      hang_cnt <= '0;
    end else begin
      key_gate <= key_in;
      if (key_in) begin
        tx_req   <= 1'b1;
        hang_cnt <= hold_ticks;
      end else if (tx_req && tick) begin
        if (hang_cnt <= HOLD_W'(1)) begin
          tx_req   <= 1'b0;
          hang_cnt <= '0;
        end else begin
          hang_cnt <= hang_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cw_hang_timer.sv
module cw_hang_timer #(
  parameter int SEL_W       = 3,
  parameter int HOLD_W      = 11,
  parameter int FULL_HOLD   = 2,
  parameter int SEMI_MIN    = 150,
  parameter int SEMI_STEP   = 100,
  parameter int PULSE_TICKS = 8,
  parameter int AVG_W       = 20,
  parameter int AVG_SHIFT   = 11,
  parameter int QUO_W       = 12,
  parameter int AUTO_SCALE  = 45875,
  parameter int AUTO_MIN    = 100,
  parameter int AUTO_MAX    = 1200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             key_in,
  input  logic             auto_en,
  input  logic [SEL_W-1:0] mode_sel,
  output logic             tx_req,
  output logic             key_gate
);
  logic [AVG_W-1:0]  avg_w;
  logic [HOLD_W-1:0] hold_w;

  cwh_rate_avg #(
    .PULSE_TICKS(PULSE_TICKS), .AVG_W(AVG_W), .AVG_SHIFT(AVG_SHIFT)
  ) u_avg (
    .clk(clk), .rst(rst), .tick(tick), .key_in(key_in),
    .auto_en(auto_en), .avg_q(avg_w)
  );

  cwh_hold_select #(
    .SEL_W(SEL_W), .HOLD_W(HOLD_W), .QUO_W(QUO_W), .FULL_HOLD(FULL_HOLD),
    .SEMI_MIN(SEMI_MIN), .SEMI_STEP(SEMI_STEP), .AUTO_SCALE(AUTO_SCALE),
    .AUTO_MIN(AUTO_MIN), .AUTO_MAX(AUTO_MAX)
  ) u_sel (
    .mode_sel(mode_sel), .auto_en(auto_en),
    .avg_hi(avg_w[AVG_W-1 -: QUO_W]), .hold_ticks(hold_w)
  );

  cwh_hold_timer #(.HOLD_W(HOLD_W)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick), .key_in(key_in),
    .hold_ticks(hold_w), .tx_req(tx_req), .key_gate(key_gate)
  );
endmodule

// File: rtl/cw_hang_timer_chk.sv
module cw_hang_timer_chk #(
  parameter int SEL_W     = 3,
  parameter int HOLD_W    = 11,
  parameter int AVG_W     = 20,
  parameter int FULL_HOLD = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              key_in,
  input logic              auto_en,
  input logic [SEL_W-1:0]  mode_sel,
  input logic              tx_req,
  input logic              key_gate,
  input logic [HOLD_W-1:0] hold_w,
  input logic [AVG_W-1:0]  avg_w
);
  a_r1_key_sets_tx: assert property (@(posedge clk) disable iff (rst)
    key_in |=> tx_req);
  a_r1_gate_high: assert property (@(posedge clk) disable iff (rst)
    key_in |=> key_gate);
  a_r1_gate_low: assert property (@(posedge clk) disable iff (rst)
    !key_in |=> !key_gate);
  a_r2_drop_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_req) |-> ($past(tick) && !$past(key_in)));
  a_r3_gate_inside_tx: assert property (@(posedge clk) disable iff (rst)
    key_gate |-> tx_req);
  a_r5_semi_longer: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && mode_sel != '0) |-> (hold_w > HOLD_W'(FULL_HOLD)));
  a_r7_avg_needs_tick: assert property (@(posedge clk) disable iff (rst)
    ($past(auto_en) && !$past(tick)) |-> $stable(avg_w));
  a_r9_avg_clear: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> (avg_w == '0));
endmodule

bind cw_hang_timer cw_hang_timer_chk #(
  .SEL_W(SEL_W), .HOLD_W(HOLD_W), .AVG_W(AVG_W), .FULL_HOLD(FULL_HOLD)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .key_in(key_in), .auto_en(auto_en),
  .mode_sel(mode_sel), .tx_req(tx_req), .key_gate(key_gate),
  .hold_w(hold_w), .avg_w(avg_w)
);

// File: tb/cw_hang_timer_test.sv
`timescale 1ns/1ps
module cw_hang_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       key_in = 1'b0;
  logic       auto_en = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic       tx_req, key_gate;

  int checks = 0;
  int errors = 0;
  int m_avg = 0;
  int m_pcnt = 0;
  int m_prev = 0;
  int m_hold = 0;

  always #2 clk = ~clk;

  cw_hang_timer uut (
    .clk(clk), .rst(rst), .tick(tick), .key_in(key_in),
    .auto_en(auto_en), .mode_sel(mode_sel),
    .tx_req(tx_req), .key_gate(key_gate)
  );

  function automatic int exp_hold();
    int q, h;
    if (auto_en) begin
      q = m_avg >> 8;
      h = (q == 0) ? 1200 : 45875 / q;
      if (h < 100) h = 100;
      if (h > 1200) h = 1200;
    end else if (mode_sel == 3'd0) h = 2;
    else h = 150 + 100 * (7 - int'(mode_sel));
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: drive inputs at negedge, update reference model after the edge.
  task automatic step(input logic k, input logic t);
    int pk;
    @(negedge clk);
    key_in = k;
    tick   = t;
    @(posedge clk);
    if (k) m_hold = exp_hold();
    if (!auto_en) m_avg = 0;
    else if (t) begin
      if (m_pcnt != 0) m_avg = m_avg + (((1 << 20) - 1 - m_avg) >> 11);
      else             m_avg = m_avg - (m_avg >> 11);
    end
    pk = int'(k);
    if (pk == 1 && m_prev == 0) m_pcnt = 8;
    else if (t && m_pcnt != 0) m_pcnt = m_pcnt - 1;
    m_prev = pk;
    #1;
  endtask

  task automatic measure(output int n);
    n = -1;
    for (int i = 1; i <= 3000; i++) begin
      step(1'b0, 1'b1);
      if (!tx_req) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic keytrain(input int period, input int on, input int cycles);
    for (int c = 0; c < cycles; c++) step((c % period) < on, 1'b1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    int n, hf, hm, hs, on, gap, c;
    bit dropped;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10 reset state
    chk(tx_req == 1'b0, "R10 tx_req", tx_req, 0);
    chk(key_gate == 1'b0, "R10 key_gate", key_gate, 0);

    // R1 immediate request and gate follow
    step(1'b1, 1'b0);
    chk(tx_req == 1'b1, "R1 tx_req on key", tx_req, 1);
    chk(key_gate == 1'b1, "R1 key_gate on key", key_gate, 1);
    step(1'b0, 1'b0);
    chk(key_gate == 1'b0, "R1 key_gate after release", key_gate, 0);
    // R2 edges without tick hold the count
    repeat (5) step(1'b0, 1'b0);
    chk(tx_req == 1'b1, "R2 no tick no drop", tx_req, 1);
    // R4 full break-in
    measure(n);
    chk(n == 2, "R4 full hang", n, 2);

    // R5 semi levels
    for (int lvl = 1; lvl <= 7; lvl++) begin
      mode_sel = 3'(lvl);
      step(1'b1, 1'b1);
      measure(n);
      chk(n == 150 + 100 * (7 - lvl), "R5 semi hang", n, 150 + 100 * (7 - lvl));
      chk(n > 2, "R5 semi longer than full", n, 3);
    end

    // R3 re-key during hang
    mode_sel = 3'd7;
    step(1'b1, 1'b1);
    dropped = 1'b0;
    repeat (100) begin
      step(1'b0, 1'b1);
      if (!tx_req) dropped = 1'b1;
    end
    step(1'b1, 1'b1);
    if (!tx_req) dropped = 1'b1;
    chk(!dropped, "R3 no drop on re-key", int'(dropped), 0);
    measure(n);
    chk(n == 150, "R3 full hang after re-key", n, 150);

    // R6/R7/R8 automatic mode, mode_sel ignored
    auto_en  = 1'b1;
    mode_sel = 3'd0;
    keytrain(20, 2, 8000);
    step(1'b1, 1'b1);
    measure(hf);
    chk(hf == m_hold, "R7 fast auto hang vs model", hf, m_hold);
    chk(hf == 100, "R8 fast hang at lower limit", hf, 100);
    mode_sel = 3'd3;
    keytrain(150, 3, 8000);
    step(1'b1, 1'b1);
    measure(hm);
    chk(hm == m_hold, "R6 medium auto hang vs model", hm, m_hold);
    keytrain(400, 5, 8000);
    step(1'b1, 1'b1);
    measure(hs);
    chk(hs == m_hold, "R7 slow auto hang vs model", hs, m_hold);
    chk(hf < hm && hm < hs, "R8 faster keying shorter hang", hm, hs);

    // R9 fast clear
    auto_en = 1'b0;
    step(1'b0, 1'b1);
    auto_en = 1'b1;
    step(1'b1, 1'b1);
    measure(n);
    chk(n == 1200, "R9 hang after clear", n, 1200);

    // Random keying with irregular ticks, automatic mode
    for (int r = 0; r < 4; r++) begin
      c = 0;
      while (c < 4000) begin
        on  = 1 + int'($urandom % 4);
        gap = 1 + int'($urandom % 30);
        repeat (on)  step(1'b1, ($urandom % 5) != 0);
        repeat (gap) step(1'b0, ($urandom % 5) != 0);
        c += on + gap;
      end
      step(1'b1, 1'b1);
      measure(n);
      chk(n == m_hold, "R7 random auto hang vs model", n, m_hold);
    end

    // Random semi settings with random re-keys
    auto_en = 1'b0;
    for (int r = 0; r < 6; r++) begin
      mode_sel = 3'($urandom % 8);
      step(1'b1, 1'b1);
      repeat (int'($urandom % 60)) step(1'b0, 1'b0);
      measure(n);
      chk(n == exp_hold(), "R5 random setting hang", n, exp_hold());
    end

    finish_run();
  end
endmodule